// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Feedback Divider

This block divides a fast input clock by a ratio N = P·B + A. It does not use one wide programmable counter. It models a dual-modulus prescaler that divides either by P or by P+1. A swallow counter chooses the modulus, and a main counter counts the prescaler cycles that make up one output period. A two-bit code picks the base modulus P. B is the number of prescaler cycles in each period, and A is how many of those cycles use the larger modulus. Because of this structure, small ratios below P² − P cannot all be reached one after another.

The divided output is a single pulse, one input clock wide, in the last cycle of every N-cycle period. The modulus-control output is high while the prescaler is dividing by P+1. A, B and the prescaler code are captured only where one period ends and the next begins, so a change of setting never alters a period that is already running. A counter reset holds the divider idle. A configuration-error flag also holds it idle, whenever B is too small or A is larger than B.

Top module: `swallow_divider`

## Requirements
- R1: In a steady run, div_out rises once every N = P·B + A input cycles and stays high for exactly one cycle. The first pulse after the divider leaves its held state comes in the N-th cycle after the first clock edge at which it is no longer held.
- R2: pre_code selects the base modulus P: 2'b00 gives 8, 2'b01 gives 16, 2'b10 gives 32 and 2'b11 gives 64.
- R3: cfg_err is high in the same cycle, with no clock edge in between, whenever b_val < 3 or b_val < a_val, and it is low otherwise.
- R4: While cfg_err is high, the divider is held. From the following cycle until cfg_err falls, div_out and mod_ctl stay low. After cfg_err falls, counting restarts as described in R1.
- R5: cnt_rst = 1 holds the divider. From the next cycle, div_out and mod_ctl are low. A period that was interrupted is discarded, and counting restarts as in R1 once cnt_rst returns to 0.
- R6: Within each period, mod_ctl is high for the first A·(P+1) input cycles and low for the remaining input cycles. With A = 0 it never rises. With A = B it is still high in the cycle that carries the pulse.
- R7: pre_code, b_val and a_val are sampled only at the boundary between periods. A change made in the middle of a period leaves that period's length unchanged, and the new ratio applies from the next period onward.
- R8: While rst_n is low, div_out and mod_ctl are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cnt_rst | input | 1 | Synchronous counter reset; holds the divider while high |
| pre_code | input | 2 | Selects the base modulus P (8, 16, 32 or 64) |
| b_val | input | 13 | Number of prescaler cycles per output period (B) |
| a_val | input | 6 | Number of those cycles that divide by P+1 (A) |
| div_out | output | 1 | One-cycle pulse at the end of each period of N cycles |
| mod_ctl | output | 1 | High while the prescaler divides by P+1 |
| cfg_err | output | 1 | High when the present B and A settings are not allowed |

## Verification
Two events can fall in the same cycle. The first is the end of the swallow phase together with the end of the period: with A = B, the last P+1 prescaler cycle is also the last cycle of the period. This case is set up with B = A = 3 and with B = A = 63. The bench then checks that mod_ctl stays high through the pulse cycle, and that the next period reloads with mod_ctl still high and with no gap. The second is a change of setting on a period that is already counting. The bench changes all three settings halfway through a period. It then checks that the pulse which closes that period still arrives after the old N with the old mod_ctl count, and that only the following periods use the new ratio.

// File: rtl/swdiv_pkg.sv
package swdiv_pkg;
  localparam int P_MAX = 64;
  localparam int PC_W  = $clog2(P_MAX + 2);

  typedef logic [PC_W-1:0] pcnt_t;

  // base modulus for a two-bit code: 8, 16, 32, 64
  function automatic pcnt_t base_mod(input logic [1:0] code);
    return pcnt_t'(8) << code;
  endfunction
endpackage

// File: rtl/swdiv_cfg_check.sv
module swdiv_cfg_check #(
  parameter int B_W = 13,
  parameter int A_W = 6
) (
  input  logic [B_W-1:0] b_val,
  input  logic [A_W-1:0] a_val,
  output logic           cfg_err
);
  localparam logic [B_W-1:0] B_MIN = B_W'(3);

  logic [B_W-1:0] a_ext;

  always_comb begin
    a_ext   = {{(B_W-A_W){1'b0}}, a_val};
    cfg_err = (b_val < B_MIN) || (b_val < a_ext);
  end
endmodule

// File: rtl/swdiv_prescaler.sv
module swdiv_prescaler
  import swdiv_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  hold,
  input  logic  active,
  input  logic  load,
  input  pcnt_t len,
  output logic  wrap
);
  pcnt_t pc_q, pc_d;
  logic  pc_en;

  always_comb begin
    pc_d  = pc_q;
    pc_en = 1'b0;
    if (hold) begin
      pc_d  = '0;
      pc_en = 1'b1;
    end else if (load) begin
      pc_d  = len - pcnt_t'(1);
      pc_en = 1'b1;
    end else if (pc_q != '0) begin
      pc_d  = pc_q - pcnt_t'(1);
      pc_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pc_q <= '0;
    else if (pc_en) pc_q <= pc_d;
  end

  assign wrap = active && (pc_q == '0);

  assert_pc_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pc_q <= pcnt_t'(P_MAX));

  assert_idle_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (pc_q == '0));
endmodule

// File: rtl/swdiv_ctrl.sv
module swdiv_ctrl
  import swdiv_pkg::*;
#(
  parameter int B_W = 13,
  parameter int A_W = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           hold,
  input  logic           wrap,
  input  logic [1:0]     pre_code,
  input  logic [B_W-1:0] b_val,
  input  logic [A_W-1:0] a_val,
  output logic           active,
  output logic           load,
  output pcnt_t          len,
  output logic           mod_ctl,
  output logic           period_end
);
  logic           act_q, act_d;
  logic [A_W-1:0] sa_q, sa_d;
  logic [B_W-1:0] sb_q, sb_d;
  logic [1:0]     code_q, code_d;
  logic           st_en;
  logic           last_pc;
  logic           start_new;

  always_comb begin
    last_pc   = wrap && (sb_q == B_W'(1));
    start_new = !act_q || last_pc;
    act_d     = act_q;
    sa_d      = sa_q;
    sb_d      = sb_q;
    code_d    = code_q;
    st_en     = 1'b0;
    load      = 1'b0;
    len       = base_mod(code_q);
    if (hold) begin
      act_d  = 1'b0;
      sa_d   = '0;
      sb_d   = '0;
      code_d = '0;
      st_en  = 1'b1;
    end else if (start_new) begin
      act_d  = 1'b1;
      sa_d   = a_val;
      sb_d   = b_val;
      code_d = pre_code;
      st_en  = 1'b1;
      load   = 1'b1;
      len    = base_mod(pre_code) + pcnt_t'(a_val != '0);
    end else if (wrap) begin
      sb_d   = sb_q - B_W'(1);
      sa_d   = (sa_q != '0) ? sa_q - A_W'(1) : '0;
      st_en  = 1'b1;
      load   = 1'b1;
      len    = base_mod(code_q) + pcnt_t'(sa_q > A_W'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      sa_q   <= '0;
      sb_q   <= '0;
      code_q <= '0;
    end else if (st_en) begin
      act_q  <= act_d;
      sa_q   <= sa_d;
      sb_q   <= sb_d;
      code_q <= code_d;
    end
  end

  assign active     = act_q;
  assign mod_ctl    = act_q && (sa_q != '0);
  assign period_end = last_pc;

  assert_main_live_R7: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |-> (sb_q != '0));

  assert_swallow_le_main_R6: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |-> ({{(B_W-A_W){1'b0}}, sa_q} <= sb_q));

  assert_code_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && !hold && !last_pc) |=> $stable(code_q));

  assert_hold_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> !act_q);
endmodule

// File: rtl/swallow_divider.sv
module swallow_divider
  import swdiv_pkg::*;
#(
  parameter int B_W = 13,
  parameter int A_W = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cnt_rst,
  input  logic [1:0]     pre_code,
  input  logic [B_W-1:0] b_val,
  input  logic [A_W-1:0] a_val,
  output logic           div_out,
  output logic           mod_ctl,
  output logic           cfg_err
);
  logic  hold;
  logic  active;
  logic  load;
  logic  wrap;
  pcnt_t len;

  swdiv_cfg_check #(.B_W(B_W), .A_W(A_W)) u_chk (
    .b_val   (b_val),
    .a_val   (a_val),
    .cfg_err (cfg_err)
  );

  assign hold = cnt_rst || cfg_err;

  swdiv_ctrl #(.B_W(B_W), .A_W(A_W)) u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .hold       (hold),
    .wrap       (wrap),
    .pre_code   (pre_code),
    .b_val      (b_val),
    .a_val      (a_val),
    .active     (active),
    .load       (load),
    .len        (len),
    .mod_ctl    (mod_ctl),
    .period_end (div_out)
  );

  swdiv_prescaler u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .hold   (hold),
    .active (active),
    .load   (load),
    .len    (len),
    .wrap   (wrap)
  );

  assert_single_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    div_out |=> !div_out);

  assert_err_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> (!div_out && !mod_ctl));
endmodule

// File: tb/sim_swallow_divider.sv
`timescale 1ns/1ps
module sim_swallow_divider;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cnt_rst;
  logic [1:0]  pre_code;
  logic [12:0] b_val;
  logic [5:0]  a_val;
  logic        div_out, mod_ctl, cfg_err;

  int checks = 0;
  int errors = 0;
  int edge_cnt = 0;
  int ref_edge = 0;
  int modc = 0;
  bit done = 0;
  int exp_gap[$];
  int exp_mod[$];
  string exp_req[$];

  always #2 clk = ~clk;

  swallow_divider u0 (
    .clk(clk), .rst_n(rst_n), .cnt_rst(cnt_rst), .pre_code(pre_code),
    .b_val(b_val), .a_val(a_val), .div_out(div_out), .mod_ctl(mod_ctl),
    .cfg_err(cfg_err)
  );

  always @(posedge clk) edge_cnt++;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor: compares each pulse against the scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (mod_ctl) modc++;
      if (div_out) begin
        if (exp_gap.size() == 0) begin
          check(1'b0, "R4/R5 unexpected pulse", edge_cnt - ref_edge, 0);
        end else begin
          string r;
          int g, m;
          r = exp_req.pop_front();
          g = exp_gap.pop_front();
          m = exp_mod.pop_front();
          check(edge_cnt - ref_edge == g, {r, " R1 period"}, edge_cnt - ref_edge, g);
          check(modc == m, {r, " R6 mod_ctl cycles"}, modc, m);
        end
        ref_edge = edge_cnt;
        modc = 0;
      end
    end
  end

  function automatic int nval(input int p, input int b, input int a);
    return (8 << p) * b + a;
  endfunction

  function automatic int mval(input int p, input int a);
    return a * ((8 << p) + 1);
  endfunction

  task automatic push(input string req, input int p, input int b, input int a, input int n);
    for (int i = 0; i < n; i++) begin
      exp_req.push_back(req);
      exp_gap.push_back(nval(p, b, a));
      exp_mod.push_back(mval(p, a));
    end
  endtask

  task automatic set_cfg(input int p, input int b, input int a);
    pre_code = 2'(p);
    b_val    = 13'(b);
    a_val    = 6'(a);
  endtask

  task automatic drain(input string req, input int limit);
    int k = 0;
    while (exp_gap.size() != 0 && k < limit) begin
      @(negedge clk); #0.5;
      k++;
    end
    if (exp_gap.size() != 0) begin
      check(1'b0, {req, " missing pulse"}, exp_gap.size(), 0);
      exp_gap.delete(); exp_mod.delete(); exp_req.delete();
    end
  endtask

  task automatic start(input int p, input int b, input int a);
    @(negedge clk);
    cnt_rst = 1'b1;
    set_cfg(p, b, a);
    @(negedge clk);
    @(negedge clk);
    ref_edge = edge_cnt;
    modc = 0;
    cnt_rst = 1'b0;
  endtask

  task automatic run_ratio(input string req, input int p, input int b, input int a, input int n);
    start(p, b, a);
    push(req, p, b, a, n);
    drain(req, n * nval(p, b, a) + 50);
    @(negedge clk);
    cnt_rst = 1'b1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    cnt_rst = 1'b1;
    set_cfg(0, 3, 0);
    repeat (3) @(negedge clk);
    check(div_out == 1'b0, "R8 div_out in reset", div_out, 0);
    check(mod_ctl == 1'b0, "R8 mod_ctl in reset", mod_ctl, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3: combinational configuration check
    set_cfg(0, 2, 0); #0.5;
    check(cfg_err == 1'b1, "R3 B=2", cfg_err, 1);
    set_cfg(0, 0, 0); #0.5;
    check(cfg_err == 1'b1, "R3 B=0", cfg_err, 1);
    set_cfg(0, 3, 3); #0.5;
    check(cfg_err == 1'b0, "R3 B=A=3", cfg_err, 0);
    set_cfg(0, 5, 6); #0.5;
    check(cfg_err == 1'b1, "R3 B<A", cfg_err, 1);
    set_cfg(0, 8191, 63); #0.5;
    check(cfg_err == 1'b0, "R3 max", cfg_err, 0);

    // R1/R2: ratios under each prescaler code
    run_ratio("R2 code10", 2, 384, 12, 2);
    run_ratio("R2 code00 A=B", 0, 3, 3, 3);
    run_ratio("R2 code01 A=0", 1, 15, 0, 3);
    run_ratio("R2 code11", 3, 10, 5, 2);
    run_ratio("R6 A=B=63", 0, 63, 63, 2);

    // R4: held while configuration is illegal
    @(negedge clk);
    cnt_rst = 1'b1;
    set_cfg(0, 2, 0);
    @(negedge clk);
    cnt_rst = 1'b0;
    modc = 0;
    repeat (300) @(negedge clk);
    check(modc == 0, "R4 mod_ctl while cfg_err", modc, 0);
    ref_edge = edge_cnt;
    modc = 0;
    set_cfg(0, 4, 1);
    push("R4 after clear", 0, 4, 1, 2);
    drain("R4", 200);
    @(negedge clk);
    cnt_rst = 1'b1;

    // R7: mid-period change keeps the running period
    start(0, 20, 4);
    push("R7 old", 0, 20, 4, 3);
    begin
      int k = 0;
      while (exp_gap.size() > 1 && k < 1000) begin
        @(negedge clk); #0.5;
        k++;
      end
    end
    repeat (80) @(negedge clk);
    set_cfg(1, 5, 5);
    push("R7 new", 1, 5, 5, 2);
    drain("R7", 1000);
    @(negedge clk);
    cnt_rst = 1'b1;

    // R5: reset in mid-period discards it
    start(1, 20, 3);
    repeat (150) @(negedge clk);
    cnt_rst = 1'b1;
    repeat (2) @(negedge clk);
    check(mod_ctl == 1'b0, "R5 mod_ctl during cnt_rst", mod_ctl, 0);
    check(div_out == 1'b0, "R5 div_out during cnt_rst", div_out, 0);
    repeat (40) @(negedge clk);
    ref_edge = edge_cnt;
    modc = 0;
    cnt_rst = 1'b0;
    push("R5 restart", 1, 20, 3, 1);
    drain("R5", 500);
    @(negedge clk);
    cnt_rst = 1'b1;
    repeat (5) @(negedge clk);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule